// File: doc/BRIEF.md
# Vector mask compress unit

This block carries out a vector compress operation on one vector register group. A mask register chooses which elements of a source group survive. The chosen elements are packed, lowest index first, into the low positions of a destination group. Every destination element above the packed ones, up to the largest element count the current grouping allows, is then written as zero.

The unit accepts a 32-bit instruction word and a one-cycle start pulse, together with the active vector length, element width code, group size code and mask layout. It decodes the instruction and checks that it is legal. It then reads the mask register once, reads one source element per cycle, and writes one destination element per cycle through register-file style ports. At the end it raises a one-cycle done pulse. An instruction that fails decode or the register checks raises a one-cycle illegal pulse and does no work. A vector length of zero completes without touching any register.

Top module: `vcmp_unit`

## Requirements
- R1: An instruction is recognised only when bits [31:26] are 010111, bits [14:12] are 010 and bits [6:0] are 1010111. Any other word is illegal. Bit 25 has no effect on the result. The register fields are rd = [11:7], rs1 (mask) = [19:15] and rs2 (source) = [24:20].
- R2: For indices i from 0 up to vl-1 in ascending order, each source element whose mask bit is set is written to destination position num, and num then increases by one. Elements with a clear mask bit use no destination slot.
- R3: After packing, destination positions num through vlmax-1 are written with zero, where vlmax = VLEN >> mlen_log2_i.
- R4: When vl_i is zero and the instruction is legal, no register is written and done_o pulses in the cycle after start.
- R5: sew_i codes 0, 1, 2 and 3 select 8, 16, 32 and 64-bit elements. Element e of a group lies at byte offset e << sew_i. Only that many bytes are written.
- R6: The instruction is illegal when rd equals rs2.
- R7: The instruction is illegal when rs1 lies within the rd group rd .. rd + 2^lmul_i - 1.
- R8: The instruction is illegal when rd or rs2 is not a multiple of 2^lmul_i.
- R9: The mask bit for element i is bit i << mlen_log2_i of register rs1. The mask is read at start.
- R10: Processing takes one element per cycle. Counting the cycle after the start edge as cycle 1, done_o is high for exactly one cycle, at cycle vl + (vlmax - num) + 1.
- R11: An illegal instruction raises illegal_o for one cycle, in cycle 1. It performs no write and produces no done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| instr_i | input | 32 | Instruction word |
| vl_i | input | IW | Active vector length |
| sew_i | input | 2 | Element width code |
| lmul_i | input | 2 | Group size code (2^lmul_i registers) |
| mlen_log2_i | input | 3 | log2 of mask bit spacing |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |
| mask_rd_reg_o | output | 5 | Mask register number |
| mask_rd_data_i | input | VLEN | Mask register contents |
| src_rd_reg_o | output | 5 | Source group base register |
| src_rd_idx_o | output | IW | Source element index |
| src_rd_data_i | input | 64 | Source element data, right-aligned |
| dst_wr_en_o | output | 1 | Destination write enable |
| dst_wr_reg_o | output | 5 | Destination group base register |
| dst_wr_idx_o | output | IW | Destination element index |
| dst_wr_sew_o | output | 2 | Width code of the write |
| dst_wr_data_o | output | 64 | Destination element data, right-aligned |

## Verification
The bench builds the unit with VLEN = 64 against a 32-register byte-addressed register model. With that size, groups of eight registers fit with room left for the source and mask registers. Mask spacings from 1 to 16 bits become reachable, so vlmax runs from 4 up to 64. The cases include a 64-element byte compress with every bit set, which has no tail, and an all-clear mask, where the whole group is tail. Every illegal encoding class is tried, and after each run the entire register file is compared so that stray writes are caught.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int unsigned ELEN = 64;

  localparam logic [6:0] OPC_VEC     = 7'b1010111;
  localparam logic [2:0] F3_MVV      = 3'b010;
  localparam logic [5:0] F6_COMPRESS = 6'b010111;

  typedef logic [4:0] vreg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PACK  = 2'd1,
    ST_CLEAR = 2'd2,
    ST_DONE  = 2'd3
  } vcmp_state_e;

  typedef struct packed {
    vreg_t rd;
    vreg_t rs1;
    vreg_t rs2;
  } vcmp_regs_t;
endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
  import vcmp_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [1:0]  lmul_i,
  output vcmp_regs_t  regs_o,
  output logic        legal_o
);
  logic       match;
  logic [5:0] grp;
  logic [4:0] align_msk;
  logic       rd_ok, rs2_ok, overlap, same;
  logic [5:0] rd_end;

  assign regs_o.rd  = instr_i[11:7];
  assign regs_o.rs1 = instr_i[19:15];
  assign regs_o.rs2 = instr_i[24:20];

  // bit 25 (vm) deliberately not decoded
  assign match = (instr_i[6:0] == OPC_VEC) && (instr_i[14:12] == F3_MVV) &&
                 (instr_i[31:26] == F6_COMPRESS);

  assign grp       = 6'd1 << lmul_i;
  assign align_msk = 5'(grp - 6'd1);
  assign rd_ok     = (regs_o.rd & align_msk) == 5'd0;
  assign rs2_ok    = (regs_o.rs2 & align_msk) == 5'd0;
  assign rd_end    = {1'b0, regs_o.rd} + grp;
  assign overlap   = ({1'b0, regs_o.rs1} >= {1'b0, regs_o.rd}) &&
                     ({1'b0, regs_o.rs1} < rd_end);
  assign same      = regs_o.rd == regs_o.rs2;

  assign legal_o = match && rd_ok && rs2_ok && !overlap && !same;
endmodule

// File: rtl/vcmp_mask_pick.sv
module vcmp_mask_pick #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned IW   = $clog2(VLEN + 1),
  parameter int unsigned MLW  = 3
) (
  input  logic [VLEN-1:0] mask_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [MLW-1:0]  mlen_log2_i,
  output logic            bit_o
);
  localparam int unsigned PW = IW + (1 << MLW);
  localparam int unsigned AW = $clog2(VLEN);

  logic [PW-1:0] pos;

  assign pos   = PW'(idx_i) << mlen_log2_i;
  assign bit_o = (pos < PW'(VLEN)) ? mask_i[pos[AW-1:0]] : 1'b0;
endmodule

// File: rtl/vcmp_elem_fmt.sv
module vcmp_elem_fmt #(
  parameter int unsigned EW = 64
) (
  input  logic [EW-1:0] data_i,
  input  logic [1:0]    sew_i,
  input  logic          zero_i,
  output logic [EW-1:0] data_o
);
  logic [EW-1:0] variant [4];

  for (genvar g = 0; g < 4; g++) begin : g_width
    localparam int unsigned W = 8 << g;
    if (W < EW) begin : g_narrow
      assign variant[g] = {{(EW - W){1'b0}}, data_i[W-1:0]};
    end else begin : g_full
      assign variant[g] = data_i;
    end
  end

  assign data_o = zero_i ? '0 : variant[sew_i];
endmodule

// File: rtl/vcmp_seq.sv
module vcmp_seq
  import vcmp_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned IW   = $clog2(VLEN + 1),
  parameter int unsigned MLW  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            legal_i,
  input  vcmp_regs_t      regs_i,
  input  logic [IW-1:0]   vl_i,
  input  logic [1:0]      sew_i,
  input  logic [MLW-1:0]  mlen_log2_i,
  input  logic [VLEN-1:0] mask_rd_data_i,
  output logic            idle_o,
  output logic            done_o,
  output logic            illegal_o,
  output vreg_t           src_reg_o,
  output logic [IW-1:0]   src_idx_o,
  output logic            wr_en_o,
  output logic            wr_zero_o,
  output vreg_t           wr_reg_o,
  output logic [IW-1:0]   wr_idx_o,
  output logic [1:0]      wr_sew_o
);
  vcmp_state_e     state_q;
  logic [IW-1:0]   idx_q, num_q, vl_q, vlmax_q, num_next, vlmax_d;
  logic [MLW-1:0]  ml_q;
  logic [1:0]      sew_q;
  vreg_t           rd_q, rs2_q;
  logic [VLEN-1:0] mask_q;
  logic            illegal_q;
  logic            sel;

  vcmp_mask_pick #(.VLEN(VLEN), .IW(IW), .MLW(MLW)) u_pick (
    .mask_i      (mask_q),
    .idx_i       (idx_q),
    .mlen_log2_i (ml_q),
    .bit_o       (sel)
  );

  assign vlmax_d  = IW'(VLEN >> mlen_log2_i);
  assign num_next = num_q + IW'(sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      num_q     <= '0;
      vl_q      <= '0;
      vlmax_q   <= '0;
      ml_q      <= '0;
      sew_q     <= '0;
      rd_q      <= '0;
      rs2_q     <= '0;
      mask_q    <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (!legal_i) begin
              illegal_q <= 1'b1;
            end else if (vl_i == '0) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_PACK;
              idx_q   <= '0;
              num_q   <= '0;
              vl_q    <= vl_i;
              vlmax_q <= vlmax_d;
              ml_q    <= mlen_log2_i;
              sew_q   <= sew_i;
              rd_q    <= regs_i.rd;
              rs2_q   <= regs_i.rs2;
              mask_q  <= mask_rd_data_i;
            end
          end
        end
        ST_PACK: begin
          idx_q <= idx_q + IW'(1);
          num_q <= num_next;
          if (idx_q == vl_q - IW'(1)) begin
            state_q <= (num_next < vlmax_q) ? ST_CLEAR : ST_DONE;
          end
        end
        ST_CLEAR: begin
          num_q <= num_q + IW'(1);
          if (num_q == vlmax_q - IW'(1)) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o    = state_q == ST_IDLE;
  assign done_o    = state_q == ST_DONE;
  assign illegal_o = illegal_q;
  assign src_reg_o = rs2_q;
  assign src_idx_o = idx_q;
  assign wr_en_o   = (state_q == ST_CLEAR) || ((state_q == ST_PACK) && sel);
  assign wr_zero_o = state_q == ST_CLEAR;
  assign wr_reg_o  = rd_q;
  assign wr_idx_o  = num_q;
  assign wr_sew_o  = sew_q;

  assert_pack_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PACK) |-> (num_q <= idx_q));

  assert_tail_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o < vlmax_q));

  assert_vl_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && start_i && legal_i && vl_i == '0) |=> (done_o && !wr_en_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_illegal_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && start_i && !legal_i) |=> (illegal_o && idle_o && !wr_en_o));
endmodule

// File: rtl/vcmp_unit.sv
module vcmp_unit
  import vcmp_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned IW   = $clog2(VLEN + 1),
  parameter int unsigned MLW  = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic [IW-1:0]   vl_i,
  input  logic [1:0]      sew_i,
  input  logic [1:0]      lmul_i,
  input  logic [MLW-1:0]  mlen_log2_i,
  output logic            done_o,
  output logic            illegal_o,
  output logic [4:0]      mask_rd_reg_o,
  input  logic [VLEN-1:0] mask_rd_data_i,
  output logic [4:0]      src_rd_reg_o,
  output logic [IW-1:0]   src_rd_idx_o,
  input  logic [ELEN-1:0] src_rd_data_i,
  output logic            dst_wr_en_o,
  output logic [4:0]      dst_wr_reg_o,
  output logic [IW-1:0]   dst_wr_idx_o,
  output logic [1:0]      dst_wr_sew_o,
  output logic [ELEN-1:0] dst_wr_data_o
);
  vcmp_regs_t regs;
  logic       legal, idle, wr_zero;

  vcmp_decode u_dec (
    .instr_i (instr_i),
    .lmul_i  (lmul_i),
    .regs_o  (regs),
    .legal_o (legal)
  );

  vcmp_seq #(.VLEN(VLEN), .IW(IW), .MLW(MLW)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .legal_i        (legal),
    .regs_i         (regs),
    .vl_i           (vl_i),
    .sew_i          (sew_i),
    .mlen_log2_i    (mlen_log2_i),
    .mask_rd_data_i (mask_rd_data_i),
    .idle_o         (idle),
    .done_o         (done_o),
    .illegal_o      (illegal_o),
    .src_reg_o      (src_rd_reg_o),
    .src_idx_o      (src_rd_idx_o),
    .wr_en_o        (dst_wr_en_o),
    .wr_zero_o      (wr_zero),
    .wr_reg_o       (dst_wr_reg_o),
    .wr_idx_o       (dst_wr_idx_o),
    .wr_sew_o       (dst_wr_sew_o)
  );

  vcmp_elem_fmt #(.EW(ELEN)) u_fmt (
    .data_i (src_rd_data_i),
    .sew_i  (dst_wr_sew_o),
    .zero_i (wr_zero),
    .data_o (dst_wr_data_o)
  );

  assign mask_rd_reg_o = regs.rs1;

  assert_rd_eq_rs2_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && instr_i[11:7] == instr_i[24:20]) |=> illegal_o);

  assert_mask_in_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && lmul_i == 2'd0 && instr_i[19:15] == instr_i[11:7]) |=> illegal_o);

  assert_bad_opcode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && start_i && instr_i[6:0] != 7'b1010111) |=> (illegal_o && !done_o));

  assert_write_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_wr_en_o && dst_wr_sew_o == 2'd0) |-> (dst_wr_data_o[ELEN-1:8] == '0));
endmodule

// File: tb/vcmp_unit_test.sv
`timescale 1ns/1ps
module vcmp_unit_test;
  localparam int VLEN = 64;
  localparam int VB   = VLEN / 8;
  localparam int RFB  = 32 * VB;
  localparam int IW   = $clog2(VLEN + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     instr = '0;
  logic [IW-1:0]   vl = '0;
  logic [1:0]      sew = '0, lmul = '0;
  logic [2:0]      ml = '0;
  logic            done, illegal;
  logic [4:0]      mask_reg, src_reg, wr_reg;
  logic [VLEN-1:0] mask_data;
  logic [IW-1:0]   src_idx, wr_idx;
  logic [63:0]     src_data, wr_data;
  logic            wr_en;
  logic [1:0]      wr_sew;
  logic [1:0]      cur_sew = '0;

  logic [7:0] rf   [RFB];
  logic [7:0] gold [RFB];
  logic [31:0] seed = 32'h1234_5679;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  vcmp_unit #(.VLEN(VLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr), .vl_i(vl),
    .sew_i(sew), .lmul_i(lmul), .mlen_log2_i(ml), .done_o(done), .illegal_o(illegal),
    .mask_rd_reg_o(mask_reg), .mask_rd_data_i(mask_data), .src_rd_reg_o(src_reg),
    .src_rd_idx_o(src_idx), .src_rd_data_i(src_data), .dst_wr_en_o(wr_en),
    .dst_wr_reg_o(wr_reg), .dst_wr_idx_o(wr_idx), .dst_wr_sew_o(wr_sew),
    .dst_wr_data_o(wr_data)
  );

  always_comb begin
    for (int b = 0; b < 8; b++)
      src_data[b*8 +: 8] = rf[(int'(src_reg) * VB + (int'(src_idx) << cur_sew) + b) % RFB];
    for (int k = 0; k < VLEN; k++)
      mask_data[k] = rf[int'(mask_reg) * VB + k / 8][k % 8];
  end

  always @(posedge clk)
    if (wr_en)
      for (int b = 0; b < 8; b++)
        if (b < (1 << wr_sew))
          rf[(int'(wr_reg) * VB + (int'(wr_idx) << wr_sew) + b) % RFB] <= wr_data[b*8 +: 8];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rnd(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic fill_rf();
    logic [31:0] r;
    for (int i = 0; i < RFB; i++) begin
      rnd(r);
      rf[i] = r[7:0];
    end
  endtask

  function automatic logic [31:0] enc(input int rd, input int rs1, input int rs2, input bit vm);
    return {6'b010111, vm, 5'(rs2), 5'(rs1), 3'b010, 5'(rd), 7'b1010111};
  endfunction

  task automatic cmp_rf(input string req);
    int bad = 0, at = 0;
    for (int i = 0; i < RFB; i++)
      if (rf[i] !== gold[i]) begin
        if (bad == 0) at = i;
        bad++;
      end
    chk(bad == 0, req, $sformatf("register file byte %0d", at),
        longint'(rf[at]), longint'(gold[at]));
  endtask

  // mode: 0 random mask, 1 all clear, 2 all set
  task automatic run_ok(input int rd, input int rs1, input int rs2, input int lm,
                        input int sw, input int n, input bit vm, input int mode,
                        input string req);
    int mlv, vlmax, num, c, exp_c;
    fill_rf();
    for (int j = 0; j < VB; j++)
      if (mode == 1) rf[rs1 * VB + j] = 8'h00;
      else if (mode == 2) rf[rs1 * VB + j] = 8'hFF;
    for (int i = 0; i < RFB; i++) gold[i] = rf[i];
    mlv = 3 + sw - lm;
    vlmax = VLEN >> mlv;
    num = 0;
    if (n > 0) begin
      for (int i = 0; i < n; i++) begin
        int pos = i << mlv;
        if (rf[rs1 * VB + pos / 8][pos % 8]) begin
          for (int b = 0; b < (1 << sw); b++)
            gold[rd * VB + (num << sw) + b] = rf[rs2 * VB + (i << sw) + b];
          num++;
        end
      end
      for (int e = num; e < vlmax; e++)
        for (int b = 0; b < (1 << sw); b++)
          gold[rd * VB + (e << sw) + b] = 8'h00;
    end
    exp_c = (n == 0) ? 1 : n + (vlmax - num) + 1;
    @(negedge clk);
    instr = enc(rd, rs1, rs2, vm);
    vl = IW'(n); sew = 2'(sw); lmul = 2'(lm); ml = 3'(mlv); cur_sew = 2'(sw);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    while (!done && c < 1000) begin
      @(negedge clk);
      c++;
    end
    chk(done && c == exp_c, req, "cycles to done", c, exp_c);
    chk(!illegal, req, "illegal_o on legal op", illegal, 0);
    cmp_rf(req);
    @(negedge clk);
    chk(!done, "R10", "done_o second cycle", done, 0);
  endtask

  task automatic run_bad(input logic [31:0] iw, input int lm, input string req);
    bit any_done = 0, any_wr = 0;
    fill_rf();
    for (int i = 0; i < RFB; i++) gold[i] = rf[i];
    @(negedge clk);
    instr = iw; lmul = 2'(lm); vl = IW'(4); sew = 2'd0; ml = 3'(3 - lm); cur_sew = 2'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(illegal === 1'b1, req, "illegal_o in cycle 1", illegal, 1);
    for (int k = 0; k < 6; k++) begin
      any_done |= done;
      any_wr |= wr_en;
      @(negedge clk);
      if (k == 0) chk(!illegal, "R11", "illegal_o pulse width", illegal, 0);
    end
    chk(!any_done && !any_wr, "R11", "done or write after illegal",
        {any_done, any_wr}, 0);
    cmp_rf(req);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    fill_rf();
    repeat (3) @(negedge clk);
    chk(!done && !illegal && !wr_en, "R10", "reset outputs", {done, illegal, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_ok(4, 1, 8, 0, 0, 8, 1'b1, 0, "R2 R9 bytes");
    run_ok(4, 0, 8, 2, 3, 4, 1'b1, 0, "R5 dwords");
    run_ok(2, 7, 6, 1, 1, 5, 1'b1, 0, "R3 partial vl");
    run_ok(8, 0, 16, 3, 2, 13, 1'b1, 0, "R5 words lmul8");
    run_ok(16, 3, 24, 3, 0, 64, 1'b1, 2, "R10 full no tail");
    run_ok(5, 6, 9, 0, 1, 4, 1'b1, 1, "R3 all tail");
    run_ok(12, 2, 20, 2, 0, 29, 1'b1, 0, "R9 spaced mask");
    run_ok(6, 1, 10, 1, 2, 0, 1'b1, 0, "R4 vl zero");
    run_ok(4, 1, 8, 0, 0, 8, 1'b0, 0, "R1 vm ignored");

    run_bad(enc(4, 1, 4, 1'b1), 0, "R6 rd eq rs2");
    run_bad(enc(4, 6, 8, 1'b1), 2, "R7 rs1 in group");
    run_bad(enc(3, 3, 9, 1'b1), 0, "R7 rs1 eq rd");
    run_bad(enc(3, 0, 4, 1'b1), 1, "R8 rd misaligned");
    run_bad(enc(4, 0, 10, 1'b1), 2, "R8 rs2 misaligned");
    run_bad(enc(4, 1, 8, 1'b1) ^ 32'h0000_2000, 0, "R1 funct3");
    run_bad(enc(4, 1, 8, 1'b1) ^ 32'h0000_0008, 0, "R1 opcode");
    run_bad(enc(4, 1, 8, 1'b1) ^ 32'h0400_0000, 0, "R1 funct6");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule